// File: doc/BRIEF.md
# Four-Channel Codec Control Register Bank

This block holds the control state of a four-channel telephony codec. A host hands it one 8-bit control word at a time on a parallel bus, qualified by a one-cycle write strobe. The two top bits of the word pick the channel. The next two bits pick one of three kinds of update. A word can assign the channel's transmit time slot, set its three relay bits, or set its codec and line-interface controls: power-up, receive gain and two line-control bits.

One flag selects delayed or nondelayed PCM timing for the whole device. Only a relay-type word addressed to channel 0 can change it. A relay-type word for channel 1 must carry a zero in the timing bit, and a violation latches a sticky protocol error. Relay-type words for channels 2 and 3 carry a timing bit that is ignored.

A frame slot counter runs beside the registers. A frame sync pulse clears it, and each slot strobe advances it. Each channel gets a transmit enable that is high while the counter equals that channel's slot and the channel is powered up. This enable is meant to drive a tristate on a shared transmit bus.

Top module: `qcc_ctrl_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge, channel n holds slot n for n = 0..3. All power-up, gain, relay and line-control bits are 0. `pcm_delayed_o`, `proto_err_o` and `cur_slot_o` are 0.
- R2: A strobed word with bit 5 (M) = 0 writes bits 4..0 into the slot of the channel in bits 7..6. The new value shows on the outputs after the next clock edge. Other channels are not affected.
- R3: A strobed word with bit 5 = 1 and bit 4 = 0 writes bits 2..0 into the selected channel's relay field. Bit 0 lands in relay bit 0.
- R4: A strobed word with bit 5 = 1 and bit 4 = 1 loads four controls of the selected channel: bit 3 into power-up, bit 2 into receive gain, bit 1 into line bit B1 and bit 0 into line bit B0.
- R5: `pcm_delayed_o` takes bit 3 of a strobed word that has bits 7..6 = 00, bit 5 = 1 and bit 4 = 0. No other word changes it.
- R6: `proto_err_o` is set by a strobed word with bits 7..6 = 01, bit 5 = 1, bit 4 = 0 and bit 3 = 1. It stays set until reset. Bit 3 of relay-type words for channels 2 and 3 has no effect on any output.
- R7: With `wr_stb_i` low, the value on `wr_word_i` changes no register.
- R8: `cur_slot_o` goes to 0 after an edge where `frame_sync_i` is high, and frame sync takes priority over the slot strobe. Otherwise it advances by one after each edge with `slot_stb_i` high, and wraps from 31 to 0.
- R9: `tx_en_o[n]` is high in the same cycle exactly when channel n is powered up and `cur_slot_o` equals channel n's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb_i | input | 1 | One-cycle write strobe for the control word |
| wr_word_i | input | 8 | Control word: channel[7:6], M[5], D4..D0[4:0] |
| frame_sync_i | input | 1 | Frame start pulse; clears the slot counter |
| slot_stb_i | input | 1 | Advances the slot counter by one |
| tx_slot_o | output | 20 | Slot of channel n at bits [5n+4:5n] |
| relay_o | output | 12 | Relay bits of channel n at bits [3n+2:3n] |
| pwr_up_o | output | 4 | Per-channel power-up |
| rx_gain_o | output | 4 | Per-channel receive gain select |
| line_b1_o | output | 4 | Per-channel line-control bit B1 |
| line_b0_o | output | 4 | Per-channel line-control bit B0 |
| pcm_delayed_o | output | 1 | Global delayed PCM timing flag |
| proto_err_o | output | 1 | Sticky protocol error |
| cur_slot_o | output | 5 | Current frame slot |
| tx_en_o | output | 4 | Per-channel transmit enable |

## Verification
Every register is brought out to a port, so a bad decode shows on the outputs one clock after the strobe that caused it. Examples are a write that lands on the wrong channel, a field taken from the wrong bits, or a timing flag written by the wrong channel. A slip in the slot counter or a bad gate on the enable shows in `tx_en_o` no later than the slot where the channel should have transmitted. The same slip can also raise `tx_en_o` in a slot where the channel should stay silent. The bench keeps a reference model and compares every output on every clock, so any such error is reported in the cycle it first appears.

// File: rtl/qcc_pkg.sv
// Shared constants and types for the codec control bank.
// Assumes the word layout channel[7:6], M[5], D4..D0[4:0].
package qcc_pkg;
    localparam int WORD_W  = 8;
    localparam int SLOT_W  = 5;
    localparam int RELAY_W = 3;
    localparam int CH_SEL_W = 2;
    localparam int NUM_CH  = 1 << CH_SEL_W;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_SLOT  = 2'd1,
        MODE_RELAY = 2'd2,
        MODE_CTRL  = 2'd3
    } qcc_mode_e;

    typedef struct packed {
        logic pwr;
        logic gain;
        logic b1;
        logic b0;
    } qcc_ctl_t;

    typedef struct packed {
        logic                valid;
        logic [CH_SEL_W-1:0] ch;
        qcc_mode_e           mode;
        logic [SLOT_W-1:0]   payload;
    } qcc_cmd_t;
endpackage

// File: rtl/qcc_word_decode.sv
// Splits a strobed control word into a command plus the global-flag and
// error-set pulses. Purely combinational; the caller registers the results.
module qcc_word_decode
    import qcc_pkg::*;
(
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] word,
    output qcc_cmd_t          cmd,
    output logic              flag_we,
    output logic              flag_val,
    output logic              err_set
);
    logic m_bit, d4_bit;
    logic [CH_SEL_W-1:0] ch_sel;

    // Field extraction and mode selection from M and D4.
    always_comb begin
        m_bit       = word[5];
        d4_bit      = word[4];
        ch_sel      = word[WORD_W-1 -: CH_SEL_W];
        cmd.valid   = wr_stb;
        cmd.ch      = ch_sel;
        cmd.payload = word[SLOT_W-1:0];
        if (!m_bit)      cmd.mode = MODE_SLOT;
        else if (!d4_bit) cmd.mode = MODE_RELAY;
        else             cmd.mode = MODE_CTRL;
        if (!wr_stb)     cmd.mode = MODE_NONE;
    end

    // Global timing flag write and channel-1 protocol check.
    always_comb begin
        flag_we  = wr_stb && m_bit && !d4_bit && (ch_sel == CH_SEL_W'(0));
        flag_val = word[3];
        err_set  = wr_stb && m_bit && !d4_bit && (ch_sel == CH_SEL_W'(1)) && word[3];
    end
endmodule

// File: rtl/qcc_chan_regs.sv
// Register set for one channel: slot, relay bits and codec controls.
// Assumes cmd is already decoded and valid for one cycle per word.
module qcc_chan_regs
    import qcc_pkg::*;
#(
    parameter int CH_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  qcc_cmd_t           cmd,
    output logic [SLOT_W-1:0]  slot_q,
    output logic [RELAY_W-1:0] relay_q,
    output qcc_ctl_t           ctl_q
);
    localparam logic [CH_SEL_W-1:0] MY_CH = CH_SEL_W'(CH_IDX);
    localparam logic [SLOT_W-1:0]   RST_SLOT = SLOT_W'(CH_IDX);

    logic hit;

    // Select match for this channel.
    always_comb hit = cmd.valid && (cmd.ch == MY_CH);

    // Slot register with its per-channel reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)                          slot_q <= RST_SLOT;
        else if (hit && cmd.mode == MODE_SLOT) slot_q <= cmd.payload;
    end

    // Relay bits register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           relay_q <= '0;
        else if (hit && cmd.mode == MODE_RELAY) relay_q <= cmd.payload[RELAY_W-1:0];
    end

    // Codec and line-interface controls.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctl_q <= '0;
        else if (hit && cmd.mode == MODE_CTRL) ctl_q <= qcc_ctl_t'(cmd.payload[3:0]);
    end

    a_r2_slot_load: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmd.mode == MODE_SLOT) |=> slot_q == $past(cmd.payload));
    a_r7_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && cmd.mode == MODE_SLOT) |=> $stable(slot_q));
    a_r3_relay_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && cmd.mode == MODE_RELAY) |=> $stable(relay_q));
    a_r4_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && cmd.mode == MODE_CTRL) |=> $stable(ctl_q));
endmodule

// File: rtl/qcc_slot_counter.sv
// Frame slot counter: cleared by frame sync, stepped by slot strobe,
// wraps naturally at 2**SLOT_W. Frame sync wins over the strobe.
module qcc_slot_counter
    import qcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              slot_stb,
    output logic [SLOT_W-1:0] cnt_q
);
    // Counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (frame_sync) cnt_q <= '0;
        else if (slot_stb)   cnt_q <= cnt_q + SLOT_W'(1);
    end

    a_r8_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> cnt_q == '0);
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && slot_stb) |=> cnt_q == SLOT_W'($past(cnt_q) + 1));
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && !slot_stb) |=> $stable(cnt_q));
endmodule

// File: rtl/qcc_ctrl_bank.sv
// Top of the codec control bank: decoder, per-channel registers, global
// timing flag, sticky error and slot-gated transmit enables.
// Assumes software avoids giving two powered channels the same slot.
module qcc_ctrl_bank
    import qcc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_stb_i,
    input  logic [7:0]                  wr_word_i,
    input  logic                        frame_sync_i,
    input  logic                        slot_stb_i,
    output logic [19:0]                 tx_slot_o,
    output logic [11:0]                 relay_o,
    output logic [3:0]                  pwr_up_o,
    output logic [3:0]                  rx_gain_o,
    output logic [3:0]                  line_b1_o,
    output logic [3:0]                  line_b0_o,
    output logic                        pcm_delayed_o,
    output logic                        proto_err_o,
    output logic [4:0]                  cur_slot_o,
    output logic [3:0]                  tx_en_o
);
    qcc_cmd_t          cmd;
    logic              flag_we, flag_val, err_set;
    logic [SLOT_W-1:0] cnt;

    qcc_word_decode u_dec (
        .wr_stb  (wr_stb_i),
        .word    (wr_word_i),
        .cmd     (cmd),
        .flag_we (flag_we),
        .flag_val(flag_val),
        .err_set (err_set)
    );

    qcc_slot_counter u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_sync(frame_sync_i),
        .slot_stb  (slot_stb_i),
        .cnt_q     (cnt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [SLOT_W-1:0]  slot;
        logic [RELAY_W-1:0] relay;
        qcc_ctl_t           ctl;

        qcc_chan_regs #(.CH_IDX(g)) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (cmd),
            .slot_q (slot),
            .relay_q(relay),
            .ctl_q  (ctl)
        );

        // Output packing and slot-gated transmit enable.
        always_comb begin
            tx_slot_o[g*SLOT_W +: SLOT_W]   = slot;
            relay_o[g*RELAY_W +: RELAY_W]   = relay;
            pwr_up_o[g]  = ctl.pwr;
            rx_gain_o[g] = ctl.gain;
            line_b1_o[g] = ctl.b1;
            line_b0_o[g] = ctl.b0;
            tx_en_o[g]   = ctl.pwr && (cnt == slot);
        end

        a_r9_en_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
            tx_en_o[g] |-> (pwr_up_o[g] && cur_slot_o == tx_slot_o[g*SLOT_W +: SLOT_W]));
    end

    // Global delayed/nondelayed PCM timing flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       pcm_delayed_o <= 1'b0;
        else if (flag_we) pcm_delayed_o <= flag_val;
    end

    // Sticky protocol error for a bad channel-1 timing bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       proto_err_o <= 1'b0;
        else if (err_set) proto_err_o <= 1'b1;
    end

    // Counter brought out.
    always_comb cur_slot_o = cnt;

    a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb_i && wr_word_i[7:4] == 4'b0010) |=> $stable(pcm_delayed_o));
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);
    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> ($stable(tx_slot_o) && $stable(relay_o) && $stable(pwr_up_o)));
endmodule

// File: tb/qcc_ctrl_bank_tb.sv
// Reference-model bench: behavioural model updated on each rising edge,
// every output compared on each falling edge.
module qcc_ctrl_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb_i = 1'b0;
    logic [7:0]  wr_word_i = '0;
    logic        frame_sync_i = 1'b0;
    logic        slot_stb_i = 1'b0;
    logic [19:0] tx_slot_o;
    logic [11:0] relay_o;
    logic [3:0]  pwr_up_o, rx_gain_o, line_b1_o, line_b0_o, tx_en_o;
    logic        pcm_delayed_o, proto_err_o;
    logic [4:0]  cur_slot_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit comparing = 0;

    // Model state.
    int m_slot[4], m_relay[4], m_pwr[4], m_gain[4], m_b1[4], m_b0[4];
    int m_flag, m_err, m_cnt;

    always #2.5 clk = ~clk;

    qcc_ctrl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb_i), .wr_word_i(wr_word_i),
        .frame_sync_i(frame_sync_i), .slot_stb_i(slot_stb_i),
        .tx_slot_o(tx_slot_o), .relay_o(relay_o), .pwr_up_o(pwr_up_o),
        .rx_gain_o(rx_gain_o), .line_b1_o(line_b1_o), .line_b0_o(line_b0_o),
        .pcm_delayed_o(pcm_delayed_o), .proto_err_o(proto_err_o),
        .cur_slot_o(cur_slot_o), .tx_en_o(tx_en_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_slot[i] = i; m_relay[i] = 0; m_pwr[i] = 0;
                m_gain[i] = 0; m_b1[i] = 0; m_b0[i] = 0;
            end
            m_flag = 0; m_err = 0; m_cnt = 0;
        end else begin
            if (wr_stb_i) begin
                int ch;
                ch = wr_word_i / 64;
                if (wr_word_i[5] == 0) m_slot[ch] = wr_word_i % 32;
                else if (wr_word_i[4] == 0) begin
                    m_relay[ch] = wr_word_i % 8;
                    if (ch == 0) m_flag = wr_word_i[3];
                    if (ch == 1 && wr_word_i[3]) m_err = 1;
                end else begin
                    m_pwr[ch] = wr_word_i[3]; m_gain[ch] = wr_word_i[2];
                    m_b1[ch] = wr_word_i[1];  m_b0[ch] = wr_word_i[0];
                end
            end
            if (frame_sync_i) m_cnt = 0;
            else if (slot_stb_i) m_cnt = (m_cnt + 1) % 32;
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            finish_run();
        end
    end

    // Full comparison on each falling edge.
    always @(negedge clk) begin
        if (comparing) begin
            for (int i = 0; i < 4; i++) begin
                check("R2", $sformatf("slot ch%0d", i), int'(tx_slot_o[i*5 +: 5]), m_slot[i]);
                check("R3", $sformatf("relay ch%0d", i), int'(relay_o[i*3 +: 3]), m_relay[i]);
                check("R4", $sformatf("pwr ch%0d", i), int'(pwr_up_o[i]), m_pwr[i]);
                check("R4", $sformatf("gain ch%0d", i), int'(rx_gain_o[i]), m_gain[i]);
                check("R4", $sformatf("b1 ch%0d", i), int'(line_b1_o[i]), m_b1[i]);
                check("R4", $sformatf("b0 ch%0d", i), int'(line_b0_o[i]), m_b0[i]);
                check("R9", $sformatf("tx_en ch%0d", i), int'(tx_en_o[i]),
                      (m_pwr[i] != 0 && m_cnt == m_slot[i]) ? 1 : 0);
            end
            check("R5", "pcm_delayed", int'(pcm_delayed_o), m_flag);
            check("R6", "proto_err", int'(proto_err_o), m_err);
            check("R8", "cur_slot", int'(cur_slot_o), m_cnt);
        end
    end

    task automatic wr(input logic [7:0] w);
        @(negedge clk);
        wr_stb_i = 1'b1; wr_word_i = w;
        @(negedge clk);
        wr_stb_i = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            slot_stb_i = 1'b1;
        end
        @(negedge clk);
        slot_stb_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 4; i++)
            check("R1", $sformatf("reset slot ch%0d", i), int'(tx_slot_o[i*5 +: 5]), i);
        check("R1", "reset pwr", int'(pwr_up_o), 0);
        check("R1", "reset relay", int'(relay_o), 0);
        check("R1", "reset flag/err", int'({pcm_delayed_o, proto_err_o}), 0);
        check("R1", "reset counter", int'(cur_slot_o), 0);
        comparing = 1;

        wr(8'b1001_0001);              // R2: ch2 slot 17
        check("R2", "ch2 slot 17", int'(tx_slot_o[14:10]), 17);
        wr(8'b0010_1101);              // R3/R5: ch0 relay 5, flag 1
        check("R5", "flag set by ch0", int'(pcm_delayed_o), 1);
        wr(8'b0110_0011);              // R6: ch1 relay, D3=0, no error
        check("R6", "no error on ch1 D3=0", int'(proto_err_o), 0);
        wr(8'b1110_1110);              // R6: ch3 relay D3=1 ignored
        check("R6", "ch3 D3 ignored err", int'(proto_err_o), 0);
        check("R5", "ch3 D3 leaves flag", int'(pcm_delayed_o), 1);
        wr(8'b0110_1011);              // R6: ch1 D3=1 -> error
        check("R6", "error latched", int'(proto_err_o), 1);
        wr(8'b0010_0000);              // R5: ch0 clears flag
        check("R5", "flag cleared", int'(pcm_delayed_o), 0);
        check("R6", "error sticky", int'(proto_err_o), 1);
        wr(8'b1011_1101);              // R4: ch2 pwr gain b0
        check("R4", "ch2 pwr", int'(pwr_up_o), 4'b0100);

        // R7: word on bus without strobe
        @(negedge clk);
        wr_word_i = 8'b1000_0011;
        repeat (3) @(negedge clk);
        check("R7", "ch2 slot unchanged", int'(tx_slot_o[14:10]), 17);

        // R8/R9: frame sync then walk to slot 17
        @(negedge clk); frame_sync_i = 1'b1; slot_stb_i = 1'b1;
        @(negedge clk); frame_sync_i = 1'b0; slot_stb_i = 1'b0;
        check("R8", "sync priority", int'(cur_slot_o), 0);
        steps(17);
        check("R9", "ch2 enable in slot 17", int'(tx_en_o), 4'b0100);
        steps(15);
        check("R8", "wrap to 0", int'(cur_slot_o), 0);

        // Mixed random traffic, compared each cycle.
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            wr_stb_i     = ($urandom % 2) == 0;
            wr_word_i    = 8'($urandom);
            frame_sync_i = ($urandom % 40) == 0;
            slot_stb_i   = ($urandom % 2) == 0;
        end
        @(negedge clk);
        wr_stb_i = 1'b0; frame_sync_i = 1'b0; slot_stb_i = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule